// File: doc/BRIEF.md
# Threshold Alert Controller

This block holds the alert and status logic of a measuring device that delivers a new set of results at the end of every conversion. On each conversion-done pulse it checks one chosen measurement (shunt, bus or power) against a 16-bit programmable limit. It also keeps three status flags: limit alert, result ready and arithmetic overflow. From these flags it drives an open-drain style alert line. The polarity of that line can be selected. In transparent mode the line follows the faults. In latch mode the line holds its state until software reads the status word.

Software writes the limit register and the control/status word, and strobes a read of the control/status word. A separate strobe marks writes to the device configuration; it carries a flag that tells whether the write selects a sleep (power-down or disabled) mode. The conversion side supplies one pulse per finished result, together with the three measurements and an overflow indication.

Top module: `alert_flag_ctrl`

## Requirements
- R1: After reset the limit reads 0, the control/status word reads 0 and `alert_oe_o` is 0.
- R2: A write to the limit register (`limit_we_i`) shows on `limit_o` from the next cycle on.
- R3: Control/status word layout: bits 15..11 select the limit function (15 shunt over, 14 shunt under, 13 bus over, 12 bus under, 11 power over); bit 10 lets the ready flag raise the alert; bit 4 is the limit-alert flag; bit 3 is the ready flag; bit 2 is the overflow flag; bit 1 is polarity; bit 0 is latch mode. Writes to bits 9..2 have no effect, and bits 9..5 read as 0.
- R4: Over functions test measurement > limit and under functions test measurement < limit. Both tests are strict. Shunt values compare as two's complement; bus and power values compare unsigned. The compare is taken only on a conversion-done pulse. If more than one select bit is set, the highest one wins. With no select bit set, no limit alert occurs.
- R5: In transparent mode (bit 0 = 0), the limit-alert flag sets on a conversion that meets the condition and clears on the next conversion that does not. A status read does not clear it.
- R6: In latch mode (bit 0 = 1), a set limit-alert flag stays set through clean conversions until the status word is read, and that read clears it.
- R7: The ready flag sets on every conversion-done pulse. It clears on a status read, or on a configuration write with `cfg_sleep_i` = 0. A configuration write with `cfg_sleep_i` = 1 leaves it unchanged.
- R8: The overflow flag sets on a conversion that reports overflow. It clears by the same mode rules as the limit-alert flag: on a conversion without overflow in transparent mode, and on a status read in latch mode.
- R9: The alert is active when the limit-alert flag is set, or when bit 10 and the ready flag are both set. `alert_oe_o` = 1 means the line is pulled low. With polarity 0, `alert_oe_o` equals active. With polarity 1, `alert_oe_o` equals not active.
- R10: If a status read and a conversion that sets a flag (limit alert, ready or overflow) fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| limit_we_i | input | 1 | Limit register write strobe |
| limit_wdata_i | input | 16 | Limit write data |
| limit_o | output | 16 | Limit register contents |
| ctrl_we_i | input | 1 | Control/status word write strobe |
| ctrl_wdata_i | input | 16 | Control/status write data |
| ctrl_re_i | input | 1 | Control/status read strobe (clears flags per R6..R8) |
| ctrl_rdata_o | output | 16 | Control/status word read data |
| cfg_we_i | input | 1 | Device configuration write strobe |
| cfg_sleep_i | input | 1 | Configuration write selects a sleep mode |
| conv_done_i | input | 1 | One-cycle pulse when a result is complete |
| conv_ovf_i | input | 1 | Arithmetic overflow in this result |
| conv_shunt_i | input | 16 | Shunt measurement, two's complement |
| conv_bus_i | input | 16 | Bus measurement, unsigned |
| conv_power_i | input | 16 | Power result, unsigned |
| alert_oe_o | output | 1 | Open-drain pull-down enable of the alert line |

## Verification
The bench attacks the comparator edges. A value equal to the limit must not alert. A negative limit with a zero shunt must alert, which an unsigned compare would miss. When two functions are selected, only the higher one may count. It checks that the two clear paths stay separate: a design that lets a read clear the flag in transparent mode, or a clean conversion clear it in latch mode, shows the wrong status word. It sends configuration writes with and without sleep to catch a ready flag that clears on both. It also puts a read and an alerting conversion in the same cycle, so that a design giving priority to the clear loses the event and reports a zero flag.

// File: rtl/alert_pkg.sv
package alert_pkg;
  localparam int DATA_W   = 16;
  localparam int CTRL_W   = 16;
  localparam int N_FUNC   = 5;
  // control/status word bit positions
  localparam int B_LATCH  = 0;
  localparam int B_POL    = 1;
  localparam int B_OVF    = 2;
  localparam int B_RDY    = 3;
  localparam int B_ALF    = 4;
  localparam int B_RDY_EN = 10;
  localparam int B_SEL_LO = 11;
  localparam int B_SEL_HI = B_SEL_LO + N_FUNC - 1;
  // function index within the select field (higher index = higher priority)
  typedef enum logic [2:0] {
    FN_PWR_OVER   = 3'd0,
    FN_BUS_UNDER  = 3'd1,
    FN_BUS_OVER   = 3'd2,
    FN_SHNT_UNDER = 3'd3,
    FN_SHNT_OVER  = 3'd4
  } func_e;
endpackage

// File: rtl/alert_func_sel.sv
module alert_func_sel #(
  parameter int N = 5
) (
  input  logic [N-1:0] sel_i,
  output logic [N-1:0] grant_o
);
  // highest set bit wins
  for (genvar i = 0; i < N; i++) begin : g_pri
    if (i == N - 1) begin : g_top
      assign grant_o[i] = sel_i[i];
    end else begin : g_low
      assign grant_o[i] = sel_i[i] & ~(|sel_i[N-1:i+1]);
    end
  end
endmodule

// File: rtl/alert_limit_cmp.sv
module alert_limit_cmp
  import alert_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [N_FUNC-1:0] grant_i,
  input  logic [W-1:0]      limit_i,
  input  logic [W-1:0]      shunt_i,
  input  logic [W-1:0]      bus_i,
  input  logic [W-1:0]      power_i,
  output logic              hit_o
);
  logic [N_FUNC-1:0] cond;

  always_comb begin
    cond                = '0;
    cond[FN_SHNT_OVER]  = $signed(shunt_i) > $signed(limit_i);
    cond[FN_SHNT_UNDER] = $signed(shunt_i) < $signed(limit_i);
    cond[FN_BUS_OVER]   = bus_i > limit_i;
    cond[FN_BUS_UNDER]  = bus_i < limit_i;
    cond[FN_PWR_OVER]   = power_i > limit_i;
  end

  assign hit_o = |(grant_i & cond);
endmodule

// File: rtl/alert_fault_flag.sv
module alert_fault_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_done_i,
  input  logic fault_i,
  input  logic latch_i,
  input  logic rd_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (conv_done_i && fault_i) begin
      flag_q <= 1'b1;                 // new event beats a same-cycle read
    end else if (conv_done_i && !latch_i) begin
      flag_q <= 1'b0;                 // clean conversion, transparent
    end else if (rd_i && latch_i) begin
      flag_q <= 1'b0;                 // status read, latched
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/alert_flag_ctrl.sv
module alert_flag_ctrl
  import alert_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              limit_we_i,
  input  logic [W-1:0]      limit_wdata_i,
  output logic [W-1:0]      limit_o,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              ctrl_re_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  input  logic              cfg_we_i,
  input  logic              cfg_sleep_i,
  input  logic              conv_done_i,
  input  logic              conv_ovf_i,
  input  logic [W-1:0]      conv_shunt_i,
  input  logic [W-1:0]      conv_bus_i,
  input  logic [W-1:0]      conv_power_i,
  output logic              alert_oe_o
);
  logic [W-1:0]      limit_q;
  logic [N_FUNC-1:0] sel_q;
  logic              rdy_en_q;
  logic              pol_q;
  logic              latch_q;
  logic [N_FUNC-1:0] grant;
  logic              hit;
  logic              alf_q;
  logic              ovf_q;
  logic              rdy_q;
  logic              alert_act;
  logic              unused_wdata;

  assign unused_wdata = ^ctrl_wdata_i[B_RDY_EN-1:B_POL+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_q <= '0;
    end else if (limit_we_i) begin
      limit_q <= limit_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= '0;
      rdy_en_q <= 1'b0;
      pol_q    <= 1'b0;
      latch_q  <= 1'b0;
    end else if (ctrl_we_i) begin
      sel_q    <= ctrl_wdata_i[B_SEL_HI:B_SEL_LO];
      rdy_en_q <= ctrl_wdata_i[B_RDY_EN];
      pol_q    <= ctrl_wdata_i[B_POL];
      latch_q  <= ctrl_wdata_i[B_LATCH];
    end
  end

  alert_func_sel #(.N(N_FUNC)) i_sel (
    .sel_i   (sel_q),
    .grant_o (grant)
  );

  alert_limit_cmp #(.W(W)) i_cmp (
    .grant_i (grant),
    .limit_i (limit_q),
    .shunt_i (conv_shunt_i),
    .bus_i   (conv_bus_i),
    .power_i (conv_power_i),
    .hit_o   (hit)
  );

  alert_fault_flag i_alf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conv_done_i (conv_done_i),
    .fault_i     (hit),
    .latch_i     (latch_q),
    .rd_i        (ctrl_re_i),
    .flag_o      (alf_q)
  );

  alert_fault_flag i_ovf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conv_done_i (conv_done_i),
    .fault_i     (conv_ovf_i),
    .latch_i     (latch_q),
    .rd_i        (ctrl_re_i),
    .flag_o      (ovf_q)
  );

  // ready flag: sleep-mode config writes leave it alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
    end else if (conv_done_i) begin
      rdy_q <= 1'b1;
    end else if (ctrl_re_i || (cfg_we_i && !cfg_sleep_i)) begin
      rdy_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_rdata_o                    = '0;
    ctrl_rdata_o[B_SEL_HI:B_SEL_LO] = sel_q;
    ctrl_rdata_o[B_RDY_EN]          = rdy_en_q;
    ctrl_rdata_o[B_ALF]             = alf_q;
    ctrl_rdata_o[B_RDY]             = rdy_q;
    ctrl_rdata_o[B_OVF]             = ovf_q;
    ctrl_rdata_o[B_POL]             = pol_q;
    ctrl_rdata_o[B_LATCH]           = latch_q;
  end

  assign alert_act  = alf_q | (rdy_en_q & rdy_q);
  assign alert_oe_o = pol_q ? ~alert_act : alert_act;
  assign limit_o    = limit_q;
endmodule

// File: rtl/alert_flag_ctrl_chk.sv
module alert_flag_ctrl_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         limit_we_i,
  input logic [W-1:0] limit_wdata_i,
  input logic [W-1:0] limit_o,
  input logic         ctrl_we_i,
  input logic         ctrl_re_i,
  input logic         conv_done_i,
  input logic         conv_ovf_i,
  input logic         hit,
  input logic         latch_q,
  input logic         alf_q,
  input logic         rdy_q,
  input logic         ovf_q
);
  a_r2_limit_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limit_we_i |=> limit_o == $past(limit_wdata_i));

  a_r4_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_done_i && !ctrl_re_i) |=> $stable(alf_q));

  a_r5_clean_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && !hit && !latch_q) |=> !alf_q);

  a_r6_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && alf_q && !ctrl_re_i && !ctrl_we_i) |=> alf_q);

  a_r7_ready_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> rdy_q);

  a_r7_ready_read_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_re_i && !conv_done_i) |=> !rdy_q);

  a_r8_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && conv_ovf_i) |=> ovf_q);

  a_r10_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && hit && ctrl_re_i) |=> alf_q);
endmodule

bind alert_flag_ctrl alert_flag_ctrl_chk #(.W(W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .limit_we_i    (limit_we_i),
  .limit_wdata_i (limit_wdata_i),
  .limit_o       (limit_o),
  .ctrl_we_i     (ctrl_we_i),
  .ctrl_re_i     (ctrl_re_i),
  .conv_done_i   (conv_done_i),
  .conv_ovf_i    (conv_ovf_i),
  .hit           (hit),
  .latch_q       (latch_q),
  .alf_q         (alf_q),
  .rdy_q         (rdy_q),
  .ovf_q         (ovf_q)
);

// File: tb/test_alert_flag_ctrl.sv
`timescale 1ns/1ps
module test_alert_flag_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        limit_we_i = 0;
  logic [15:0] limit_wdata_i = 0;
  logic [15:0] limit_o;
  logic        ctrl_we_i = 0;
  logic [15:0] ctrl_wdata_i = 0;
  logic        ctrl_re_i = 0;
  logic [15:0] ctrl_rdata_o;
  logic        cfg_we_i = 0;
  logic        cfg_sleep_i = 0;
  logic        conv_done_i = 0;
  logic        conv_ovf_i = 0;
  logic [15:0] conv_shunt_i = 0;
  logic [15:0] conv_bus_i = 0;
  logic [15:0] conv_power_i = 0;
  logic        alert_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_limit;
  logic [4:0]  m_sel;
  bit m_ren, m_pol, m_latch, m_alf, m_rdy, m_ovf;

  always #4 clk = ~clk;

  alert_flag_ctrl i_alert_flag_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .limit_we_i(limit_we_i), .limit_wdata_i(limit_wdata_i), .limit_o(limit_o),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i), .ctrl_re_i(ctrl_re_i),
    .ctrl_rdata_o(ctrl_rdata_o), .cfg_we_i(cfg_we_i), .cfg_sleep_i(cfg_sleep_i),
    .conv_done_i(conv_done_i), .conv_ovf_i(conv_ovf_i), .conv_shunt_i(conv_shunt_i),
    .conv_bus_i(conv_bus_i), .conv_power_i(conv_power_i), .alert_oe_o(alert_oe_o)
  );

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit ref_hit();
    if (m_sel[4]) return $signed(conv_shunt_i) > $signed(m_limit);
    if (m_sel[3]) return $signed(conv_shunt_i) < $signed(m_limit);
    if (m_sel[2]) return conv_bus_i > m_limit;
    if (m_sel[1]) return conv_bus_i < m_limit;
    if (m_sel[0]) return conv_power_i > m_limit;
    return 0;
  endfunction

  function automatic logic [15:0] exp_word();
    return {m_sel, m_ren, 5'b0, m_alf, m_rdy, m_ovf, m_pol, m_latch};
  endfunction

  function automatic bit exp_oe();
    bit act;
    act = m_alf || (m_ren && m_rdy);
    return m_pol ? !act : act;
  endfunction

  // advance one clock with current inputs, then compare at the falling edge
  task automatic tick(string req);
    bit hit, n_alf, n_ovf, n_rdy;
    hit = conv_done_i && ref_hit();
    n_alf = m_alf; n_ovf = m_ovf; n_rdy = m_rdy;
    if (hit) n_alf = 1;
    else if (conv_done_i && !m_latch) n_alf = 0;
    else if (ctrl_re_i && m_latch) n_alf = 0;
    if (conv_done_i && conv_ovf_i) n_ovf = 1;
    else if (conv_done_i && !m_latch) n_ovf = 0;
    else if (ctrl_re_i && m_latch) n_ovf = 0;
    if (conv_done_i) n_rdy = 1;
    else if (ctrl_re_i || (cfg_we_i && !cfg_sleep_i)) n_rdy = 0;
    if (limit_we_i) m_limit = limit_wdata_i;
    if (ctrl_we_i) begin
      m_sel = ctrl_wdata_i[15:11]; m_ren = ctrl_wdata_i[10];
      m_pol = ctrl_wdata_i[1]; m_latch = ctrl_wdata_i[0];
    end
    m_alf = n_alf; m_ovf = n_ovf; m_rdy = n_rdy;
    @(posedge clk);
    @(negedge clk);
    check(req, "status word", ctrl_rdata_o, exp_word());
    check(req, "limit", limit_o, m_limit);
    check(req, "alert_oe", {15'b0, alert_oe_o}, {15'b0, exp_oe()});
    limit_we_i = 0; ctrl_we_i = 0; ctrl_re_i = 0; cfg_we_i = 0;
    cfg_sleep_i = 0; conv_done_i = 0; conv_ovf_i = 0;
  endtask

  task automatic wr_limit(logic [15:0] v, string req);
    limit_we_i = 1; limit_wdata_i = v; tick(req);
  endtask
  task automatic wr_ctrl(logic [15:0] v, string req);
    ctrl_we_i = 1; ctrl_wdata_i = v; tick(req);
  endtask
  task automatic rd_ctrl(string req);
    ctrl_re_i = 1; tick(req);
  endtask
  task automatic conv(logic [15:0] sh, logic [15:0] bs, logic [15:0] pw, bit ov, string req);
    conv_done_i = 1; conv_shunt_i = sh; conv_bus_i = bs; conv_power_i = pw;
    conv_ovf_i = ov; tick(req);
  endtask
  task automatic cfg(bit sleep, string req);
    cfg_we_i = 1; cfg_sleep_i = sleep; tick(req);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    m_limit = 0; m_sel = 0; m_ren = 0; m_pol = 0; m_latch = 0;
    m_alf = 0; m_rdy = 0; m_ovf = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    tick("R1");
    check("R1", "reset word", ctrl_rdata_o, 16'h0000);
    check("R1", "reset oe", {15'b0, alert_oe_o}, 16'h0000);

    // R2 limit register
    wr_limit(16'h1234, "R2");
    check("R2", "limit readback", limit_o, 16'h1234);
    wr_limit(16'hFFFF, "R2");

    // R3 layout: flag bits and unused bits not writable
    wr_ctrl(16'hFFFF, "R3");
    check("R3", "all-ones write", ctrl_rdata_o, 16'hFC03);
    wr_ctrl(16'h0000, "R3");

    // R4/R5 bus over, transparent
    wr_limit(16'd100, "R4");
    wr_ctrl(16'h2000, "R4");
    conv(0, 16'd100, 0, 0, "R4");
    check("R4", "equal is not over", ctrl_rdata_o & 16'h0010, 16'h0000);
    conv(0, 16'd101, 0, 0, "R5");
    check("R5", "alert set", ctrl_rdata_o & 16'h0010, 16'h0010);
    check("R9", "oe active-low", {15'b0, alert_oe_o}, 16'h0001);
    conv_bus_i = 16'd0; tick("R4");       // no conversion: no change
    rd_ctrl("R5");                        // read does not clear in transparent
    check("R5", "read keeps flag", ctrl_rdata_o & 16'h0010, 16'h0010);
    conv(0, 16'd50, 0, 0, "R5");
    check("R5", "clean clears", ctrl_rdata_o & 16'h0010, 16'h0000);

    // R4 signed shunt compares
    wr_limit(16'hFFF0, "R4");
    wr_ctrl(16'h8000, "R4");
    conv(16'h0000, 0, 0, 0, "R4");
    check("R4", "signed over", ctrl_rdata_o & 16'h0010, 16'h0010);
    wr_limit(16'h0000, "R4");
    wr_ctrl(16'h4000, "R4");
    conv(16'h8000, 0, 0, 0, "R4");
    check("R4", "signed under", ctrl_rdata_o & 16'h0010, 16'h0010);
    // priority: shunt over beats bus under
    wr_limit(16'd10, "R4");
    wr_ctrl(16'h9000, "R4");
    conv(16'd5, 16'd0, 0, 0, "R4");
    check("R4", "priority", ctrl_rdata_o & 16'h0010, 16'h0000);
    wr_ctrl(16'h0800, "R4");
    conv(0, 0, 16'd11, 0, "R4");
    check("R4", "power over", ctrl_rdata_o & 16'h0010, 16'h0010);
    wr_ctrl(16'h0000, "R4");
    conv(16'h7FFF, 16'hFFFF, 16'hFFFF, 0, "R4");

    // R6 latch mode
    wr_ctrl(16'h2001, "R6");
    conv(0, 16'd200, 0, 0, "R6");
    conv(0, 16'd1, 0, 0, "R6");
    check("R6", "latched through clean", ctrl_rdata_o & 16'h0010, 16'h0010);
    rd_ctrl("R6");
    check("R6", "read clears", ctrl_rdata_o & 16'h0010, 16'h0000);

    // R7 ready flag rules
    conv(0, 0, 0, 0, "R7");
    cfg(1, "R7");
    check("R7", "sleep cfg keeps", ctrl_rdata_o & 16'h0008, 16'h0008);
    cfg(0, "R7");
    check("R7", "cfg clears", ctrl_rdata_o & 16'h0008, 16'h0000);
    conv(0, 0, 0, 0, "R7");
    rd_ctrl("R7");
    check("R7", "read clears", ctrl_rdata_o & 16'h0008, 16'h0000);

    // R8 overflow in both modes
    wr_ctrl(16'h0000, "R8");
    conv(0, 0, 0, 1, "R8");
    check("R8", "ovf set", ctrl_rdata_o & 16'h0004, 16'h0004);
    conv(0, 0, 0, 0, "R8");
    check("R8", "ovf transparent clear", ctrl_rdata_o & 16'h0004, 16'h0000);
    wr_ctrl(16'h0001, "R8");
    conv(0, 0, 0, 1, "R8");
    conv(0, 0, 0, 0, "R8");
    check("R8", "ovf latched", ctrl_rdata_o & 16'h0004, 16'h0004);
    rd_ctrl("R8");

    // R9 ready-driven alert and polarity
    wr_ctrl(16'h0400, "R9");
    conv(0, 0, 0, 0, "R9");
    check("R9", "ready alert low", {15'b0, alert_oe_o}, 16'h0001);
    wr_ctrl(16'h0402, "R9");
    check("R9", "ready alert high", {15'b0, alert_oe_o}, 16'h0000);
    rd_ctrl("R9");
    check("R9", "idle high-pol", {15'b0, alert_oe_o}, 16'h0001);

    // R10 read and event in the same cycle
    wr_limit(16'd10, "R10");
    wr_ctrl(16'h2001, "R10");
    ctrl_re_i = 1; conv_done_i = 1; conv_bus_i = 16'd20; conv_ovf_i = 1;
    tick("R10");
    check("R10", "event wins", ctrl_rdata_o & 16'h001C, 16'h001C);
    rd_ctrl("R10");
    repeat (3) tick("R10");

    done = 1;
    summary();
  end
endmodule